// File: doc/BRIEF.md
# I2S to Dual-Line PCM Converter

This block takes a standard I2S stereo stream and turns it into the format that non-oversampling multibit DACs expect. Each channel leaves on its own serial data line, most significant bit first. The two lines share one output bit clock and one latch strobe, so both channels are converted at the same moment. A receiver half and a transmitter half run independently of each other. A pair of holding registers sits between them, and the two registers are loaded together once a full stereo frame has been captured.

All logic runs on one fast system clock. The incoming bit clock, word select and data are synchronised into that domain and treated as sampled signals. A static rate input selects the output bit clock. It either follows the incoming bit clock or runs at exactly half of it, so a DAC with a slow serial port can still be used at 352.8 or 384 kHz. The output clock and the latch strobe are each driven on two identical pins, which suits dual-mono DAC boards.

Top module: `i2s2pcm_top`

## Requirements
- R1: The receiver samples word select and data on rising bit clock edges. The first data bit of a slot arrives one bit after word select changes. Word select low marks the left channel and word select high marks the right. The first 24 bits of each 32-bit slot are captured and the remaining 8 slot bits are ignored.
- R2: Both holding registers load in the same cycle, and only when a right word completes after a left word has completed. Each such pair produces exactly one output word on each data line. No other output word is produced.
- R3: The left sample is sent on `pcm_dat_l` and the right sample on `pcm_dat_r`, simultaneously and MSB first. The data lines change only on falling edges of the output clock, so a DAC samples them on rising edges.
- R4: With `half_rate` = 0 the output clock has the same period as the incoming bit clock. There are 64 output clocks per frame: 24 data bits followed by 40 bits driven low.
- R5: With `half_rate` = 1 the output clock has twice the period of the incoming bit clock. There are 32 output clocks per frame: 24 data bits followed by 8 bits driven low.
- R6: The latch strobe falls on the output clock falling edge that follows the LSB, and the data lines are low in that cycle. It rises again on the falling edge after the first rising edge of the next word. While the latch is low, the number of rising edges is therefore the frame length minus 23.
- R7: `pcm_clk_a` always equals `pcm_clk_b`, and `pcm_lat_a` always equals `pcm_lat_b`.
- R8: While `rst_n` is low, the latch outputs are high and the data and clock outputs are low. Any partly received or partly sent word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be several times faster than the I2S bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i2s_bclk | input | 1 | Incoming I2S bit clock, 64 per stereo frame |
| i2s_ws | input | 1 | Incoming word select (low = left) |
| i2s_sd | input | 1 | Incoming serial data, MSB first |
| half_rate | input | 1 | Static rate select: 0 = output clock at bit clock rate, 1 = half of it |
| pcm_clk_a | output | 1 | Output bit clock, copy A |
| pcm_clk_b | output | 1 | Output bit clock, copy B |
| pcm_lat_a | output | 1 | Latch strobe, copy A (transfer on low) |
| pcm_lat_b | output | 1 | Latch strobe, copy B |
| pcm_dat_l | output | 1 | Left channel serial data |
| pcm_dat_r | output | 1 | Right channel serial data |

## Verification
The receiver can finish a right word and load the holding registers in the very cycle that the transmitter steps on an output clock falling edge. It can also load them while the transmitter is still driving the low tail of the previous word. Running the same stream in both rate modes moves the load to different points in the transmitter's sequence. The output words are compared against the sent pairs by a model DAC that samples on rising output clock edges and checks each word when the latch falls. A pending-start flag that is lost or applied twice shows up as a missing word, an extra word, or a wrong count of output clocks between two latch falls.

// File: rtl/i2s2pcm_pkg.sv
// Package: shared constants and types for the I2S to dual-line PCM converter.
// Assumes a 64-bit-clock stereo I2S frame (two 32-bit slots).
package i2s2pcm_pkg;
    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;

    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } rate_e;
endpackage

// File: rtl/i2s2pcm_front.sv
// Module: input front end. Brings the I2S pins into the system clock domain
// through two flops and flags the bit clock edges.
// Assumes clk is at least four times the I2S bit clock.
module i2s2pcm_front (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic ws,
    input  logic sd,
    output logic bclk_s,
    output logic ws_s,
    output logic sd_s,
    output logic rise,
    output logic edge_any
);
    logic [2:0] meta_q;
    logic       bclk_p;

    // Two-stage synchroniser for the three pins, plus the previous bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            bclk_s <= 1'b0;
            ws_s   <= 1'b1;
            sd_s   <= 1'b0;
            bclk_p <= 1'b0;
        end else begin
            meta_q <= {bclk, ws, sd};
            bclk_s <= meta_q[2];
            ws_s   <= meta_q[1];
            sd_s   <= meta_q[0];
            bclk_p <= bclk_s;
        end
    end

    // Edge flags of the synchronised bit clock.
    always_comb begin
        rise     = bclk_s & ~bclk_p;
        edge_any = bclk_s ^ bclk_p;
    end
endmodule

// File: rtl/i2s2pcm_rx.sv
// Module: I2S receiver. Captures the first WORD_W bits of each slot after the
// one-bit delay that follows a word-select change, stages the left word, and
// loads both holding registers together when the matching right word ends.
// Assumes ws low = left channel.
module i2s2pcm_rx #(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              ws_s,
    input  logic              sd_s,
    output logic              pair_vld,
    output logic [WORD_W-1:0] hold_l,
    output logic [WORD_W-1:0] hold_r
);
    localparam int CW = $clog2(SLOT_W + 1);

    logic              ws_prev;
    logic [CW-1:0]     bit_idx;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] left_stage;
    logic              left_ok;
    logic [WORD_W-1:0] word_nxt;

    // Word as it stands once the current bit is shifted in.
    always_comb word_nxt = {shreg[WORD_W-2:0], sd_s};

    // Slot tracking, bit capture and the paired holding-register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev    <= 1'b1;
            bit_idx    <= CW'(SLOT_W);
            shreg      <= '0;
            left_stage <= '0;
            left_ok    <= 1'b0;
            pair_vld   <= 1'b0;
            hold_l     <= '0;
            hold_r     <= '0;
        end else begin
            pair_vld <= 1'b0;
            if (rise) begin
                ws_prev <= ws_s;
                if (ws_s != ws_prev) begin
                    bit_idx <= '0;
                end else begin
                    if (bit_idx < CW'(SLOT_W))
                        bit_idx <= bit_idx + 1'b1;
                    if (bit_idx < CW'(WORD_W)) begin
                        shreg <= word_nxt;
                        if (bit_idx == CW'(WORD_W - 1)) begin
                            if (!ws_s) begin
                                left_stage <= word_nxt;
                                left_ok    <= 1'b1;
                            end else if (left_ok) begin
                                hold_l   <= left_stage;
                                hold_r   <= word_nxt;
                                pair_vld <= 1'b1;
                                left_ok  <= 1'b0;
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2s2pcm_tx.sv
// Module: PCM transmitter. Generates the output bit clock (full or half rate),
// shifts both holding words out MSB first on falling output edges, fills the
// tail with zeros and drives the latch strobe.
// Assumes at most one load per output frame.
module i2s2pcm_tx #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_rate,
    input  logic              bclk_s,
    input  logic              rise,
    input  logic              edge_any,
    input  logic              load,
    input  logic [WORD_W-1:0] hold_l,
    input  logic [WORD_W-1:0] hold_r,
    output logic              oclk,
    output logic              latch,
    output logic              dat_l,
    output logic              dat_r
);
    import i2s2pcm_pkg::*;

    localparam int BW = $clog2(WORD_W + 2);

    rate_e             rate;
    logic              tick;
    logic              fall_ev;
    logic              go;
    logic              start_pend;
    logic [BW-1:0]     sent;
    logic [WORD_W-1:0] sh_l;
    logic [WORD_W-1:0] sh_r;

    // Output-clock step and falling-edge events for the selected rate.
    always_comb begin
        rate    = rate_e'(half_rate);
        tick    = (rate == RATE_HALF) ? rise : edge_any;
        fall_ev = (rate == RATE_HALF) ? (rise & oclk) : (edge_any & ~bclk_s);
        go      = start_pend | load;
    end

    // Output clock register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oclk <= 1'b0;
        else if (tick)
            oclk <= (rate == RATE_HALF) ? ~oclk : bclk_s;
    end

    // Word sequencing: start, shift, zero tail and latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
            sent       <= BW'(WORD_W + 1);
            sh_l       <= '0;
            sh_r       <= '0;
            dat_l      <= 1'b0;
            dat_r      <= 1'b0;
            latch      <= 1'b1;
        end else if (fall_ev) begin
            if (go) begin
                start_pend <= 1'b0;
                dat_l      <= hold_l[WORD_W-1];
                dat_r      <= hold_r[WORD_W-1];
                sh_l       <= hold_l << 1;
                sh_r       <= hold_r << 1;
                sent       <= BW'(1);
            end else if (sent < BW'(WORD_W)) begin
                dat_l <= sh_l[WORD_W-1];
                dat_r <= sh_r[WORD_W-1];
                sh_l  <= sh_l << 1;
                sh_r  <= sh_r << 1;
                sent  <= sent + 1'b1;
                if (sent == BW'(1))
                    latch <= 1'b1;
            end else if (sent == BW'(WORD_W)) begin
                dat_l <= 1'b0;
                dat_r <= 1'b0;
                latch <= 1'b0;
                sent  <= BW'(WORD_W + 1);
            end
        end else if (load) begin
            start_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/i2s2pcm_top.sv
// Module: I2S to dual-line PCM converter top. Chains the front end, the
// receiver with its holding registers and the transmitter, and fans the
// clock and latch out to two pins each.
// Assumes clk is at least four times the I2S bit clock; half_rate is static.
module i2s2pcm_top #(
    parameter int WORD_W = 24,
    parameter int SLOT_W = i2s2pcm_pkg::SLOT_BITS,
    parameter int COPIES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i2s_bclk,
    input  logic i2s_ws,
    input  logic i2s_sd,
    input  logic half_rate,
    output logic pcm_clk_a,
    output logic pcm_clk_b,
    output logic pcm_lat_a,
    output logic pcm_lat_b,
    output logic pcm_dat_l,
    output logic pcm_dat_r
);
    logic              bclk_s, ws_s, sd_s, rise, edge_any;
    logic              pair_vld;
    logic [WORD_W-1:0] hold_l, hold_r;
    logic              oclk, latch;
    logic [COPIES-1:0] clk_fan, lat_fan;

    i2s2pcm_front u_front (
        .clk(clk), .rst_n(rst_n), .bclk(i2s_bclk), .ws(i2s_ws), .sd(i2s_sd),
        .bclk_s(bclk_s), .ws_s(ws_s), .sd_s(sd_s), .rise(rise), .edge_any(edge_any)
    );

    i2s2pcm_rx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .ws_s(ws_s), .sd_s(sd_s),
        .pair_vld(pair_vld), .hold_l(hold_l), .hold_r(hold_r)
    );

    i2s2pcm_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .bclk_s(bclk_s),
        .rise(rise), .edge_any(edge_any), .load(pair_vld),
        .hold_l(hold_l), .hold_r(hold_r),
        .oclk(oclk), .latch(latch), .dat_l(pcm_dat_l), .dat_r(pcm_dat_r)
    );

    // Fan the shared clock and latch out to the pin copies.
    for (genvar g = 0; g < COPIES; g++) begin : g_fan
        assign clk_fan[g] = oclk;
        assign lat_fan[g] = latch;
    end

    assign pcm_clk_a = clk_fan[0];
    assign pcm_clk_b = clk_fan[COPIES-1];
    assign pcm_lat_a = lat_fan[0];
    assign pcm_lat_b = lat_fan[COPIES-1];
endmodule

// File: rtl/i2s2pcm_chk.sv
// Module: assertion checker for i2s2pcm_top, attached by bind below.
module i2s2pcm_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oclk,
    input logic              latch,
    input logic              dat_l,
    input logic              dat_r,
    input logic              pair_vld,
    input logic [WORD_W-1:0] hold_l,
    input logic [WORD_W-1:0] hold_r
);
    // R8: first cycle out of reset shows the idle state.
    assert_reset_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch && !dat_l && !dat_r && !oclk));

    // R3: data and latch move only together with a falling output clock.
    assert_fall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({latch, dat_l, dat_r}) |-> $fell(oclk));

    // R6: when the latch drops, the data lines are already in the zero tail.
    assert_zero_at_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch) |-> (!dat_l && !dat_r));

    // R2: the holding pair only ever changes with the load pulse.
    assert_paired_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({hold_l, hold_r}) |-> pair_vld);
endmodule

bind i2s2pcm_top i2s2pcm_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .oclk(oclk), .latch(latch),
    .dat_l(pcm_dat_l), .dat_r(pcm_dat_r), .pair_vld(pair_vld),
    .hold_l(hold_l), .hold_r(hold_r)
);

// File: tb/i2s2pcm_top_tb.sv
`timescale 1ns/1ps
module i2s2pcm_top_tb;
    localparam int NV = 6;
    // Stimulus and expected pairs: {left[47:24], right[23:0]}; output must equal input.
    localparam logic [47:0] VEC [NV] = '{
        48'h800000_7FFFFF,
        48'hFFFFFF_000000,
        48'hA5A5A5_5A5A5A,
        48'h000001_800001,
        48'h123456_FEDCBA,
        48'h000000_FFFFFF
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, ws = 1'b1, sd = 1'b0, half_rate = 1'b0;
    logic pcm_clk_a, pcm_clk_b, pcm_lat_a, pcm_lat_b, pcm_dat_l, pcm_dat_r;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2s2pcm_top u_dut (
        .clk(clk), .rst_n(rst_n), .i2s_bclk(bclk), .i2s_ws(ws), .i2s_sd(sd),
        .half_rate(half_rate), .pcm_clk_a(pcm_clk_a), .pcm_clk_b(pcm_clk_b),
        .pcm_lat_a(pcm_lat_a), .pcm_lat_b(pcm_lat_b),
        .pcm_dat_l(pcm_dat_l), .pcm_dat_r(pcm_dat_r)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model DAC: state driven only by this monitor; mon_en and exp_n from stimulus.
    bit          mon_en = 1'b0;
    int          exp_n = 64, exp_per = 8;
    bit          first_fall, prev_o, prev_lat;
    logic [63:0] sh_l, sh_r;
    int          rises, low_rises, last_rise, cyc, got, dual_bad, per_bad;

    always @(negedge clk) begin
        if (!mon_en) begin
            first_fall = 1; prev_o = 0; prev_lat = 1; rises = 0; low_rises = 0;
            sh_l = '0; sh_r = '0; last_rise = -1; cyc = 0; got = 0;
            dual_bad = 0; per_bad = 0;
        end else begin
            cyc++;
            if (pcm_clk_a !== pcm_clk_b || pcm_lat_a !== pcm_lat_b) dual_bad++;
            if (pcm_clk_a && !prev_o) begin
                sh_l = {sh_l[62:0], pcm_dat_l};
                sh_r = {sh_r[62:0], pcm_dat_r};
                rises++;
                if (!pcm_lat_a) low_rises++;
                if (last_rise >= 0 && (cyc - last_rise) != exp_per) per_bad++;
                last_rise = cyc;
            end
            if (!pcm_lat_a && prev_lat) begin
                if (got < NV) begin
                    chk(sh_l[23:0] == VEC[got][47:24], "R1 R3 left word", 64'(sh_l[23:0]), 64'(VEC[got][47:24]));
                    chk(sh_r[23:0] == VEC[got][23:0], "R1 R3 right word", 64'(sh_r[23:0]), 64'(VEC[got][23:0]));
                end else begin
                    chk(1'b0, "R2 extra word", 64'(got), 64'(NV));
                end
                if (exp_n == 64)
                    chk((sh_l[63:24] | sh_r[63:24]) == 0, "R4 zero tail", sh_l | sh_r, 64'(sh_l[23:0] | sh_r[23:0]));
                else
                    chk((sh_l[31:24] | sh_r[31:24]) == 0, "R5 zero tail", 64'(sh_l[31:0] | sh_r[31:0]), 64'(sh_l[23:0] | sh_r[23:0]));
                if (!first_fall)
                    chk(rises == exp_n, "R4 R5 clocks per frame", 64'(rises), 64'(exp_n));
                first_fall = 0; rises = 0; low_rises = 0; got++;
            end
            if (pcm_lat_a && !prev_lat)
                chk(low_rises == exp_n - 23, "R6 latch low span", 64'(low_rises), 64'(exp_n - 23));
            prev_o = pcm_clk_a;
            prev_lat = pcm_lat_a;
        end
    end

    task automatic send_bit(input logic w, input logic d);
        bclk = 1'b0; ws = w; sd = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic reset_check(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; mon_en = 1'b0; half_rate = mode; bclk = 1'b0; ws = 1'b1; sd = 1'b0;
        repeat (6) @(negedge clk);
        chk(pcm_lat_a && pcm_lat_b, "R8 latch high in reset", 64'({pcm_lat_a, pcm_lat_b}), 64'h3);
        chk(!pcm_dat_l && !pcm_dat_r && !pcm_clk_a, "R8 data and clock low in reset",
            64'({pcm_dat_l, pcm_dat_r, pcm_clk_a}), 64'h0);
    endtask

    task automatic run(input logic mode);
        reset_check(mode);
        exp_n   = mode ? 32 : 64;
        exp_per = mode ? 16 : 8;
        rst_n = 1'b1; mon_en = 1'b1;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        for (int f = 0; f < NV; f++) begin
            for (int j = 0; j < 32; j++)       // left slot, filler bits high (R1 discard)
                send_bit(j == 31, (j < 24) ? VEC[f][47 - j] : 1'b1);
            for (int j = 0; j < 32; j++)       // right slot
                send_bit(j != 31, (j < 24) ? VEC[f][23 - j] : 1'b1);
        end
        for (int i = 0; i < 200; i++) send_bit(1'b0, 1'b0);  // lone left words: no output (R2)
        chk(got == NV, "R2 words emitted", 64'(got), 64'(NV));
        chk(dual_bad == 0, "R7 pin copies equal", 64'(dual_bad), 64'h0);
        chk(per_bad == 0, mode ? "R5 half-rate period" : "R4 full-rate period", 64'(per_bad), 64'h0);
    endtask

    initial begin
        run(1'b0);
        run(1'b1);
        // Corner: reset in the middle of a word drops it at once (R8).
        @(negedge clk);
        mon_en = 1'b0; rst_n = 1'b1; half_rate = 1'b0;
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        for (int j = 0; j < 32; j++) send_bit(j == 31, 1'b1);
        for (int j = 0; j < 32; j++) send_bit(j != 31, 1'b1);
        for (int j = 0; j < 10; j++) send_bit(1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(pcm_lat_a && !pcm_dat_l && !pcm_dat_r, "R8 mid-word reset",
            64'({pcm_lat_a, pcm_dat_l, pcm_dat_r}), 64'h4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule